// File: doc/BRIEF.md
# Second-Order Vector Beam Stepper

This block produces a sequence of beam positions for an XY vector display. Position, velocity and acceleration for both axes are held as 24-bit fixed-point words: 12 integer bits above 12 fraction bits. Because the fraction is kept, the beam can move by less than one DAC code per step, which gives any slope without a Bresenham-style error term. On every step the block first adds acceleration to velocity, then adds velocity to position. It then presents the integer part of each position as a 12-bit DAC code, together with a one-cycle valid strobe.

A host writes the six state words and a 16-bit step count through a select-and-data load port while the block is idle, then pulses start. All four additions in a step go through a single shared two's-complement adder. A small controller steers the adder across a six-entry register file. Negative motion is written as a two's-complement delta, so no subtractor is needed.

With zero acceleration the block draws straight lines at constant speed. With non-zero acceleration it draws parabolic arcs, or it draws a straight line whose speed changes along its length. The state words keep their values after a run, so a later start carries on from where the beam stopped.

Top module: `curve_stepper`

## Requirements
- R1: After reset, busy, done and out_valid are low and out_x and out_y are 0.
- R2: With both accelerations zero, step k (counting from 1) emits out_x = bits [23:12] of (X0 + k·dx) and out_y likewise for Y. Fractional deltas accumulate, so a delta of 0x000800 (half a code) advances the output by one code every second step.
- R3: Velocity is updated before position within a step: step 1 emits the integer part of X0 + dx0 + ddx, and step k uses dx_k = dx0 + k·ddx and X_k = X_(k-1) + dx_k. The same holds for Y.
- R4: Deltas are two's complement and every addition wraps modulo 2^24. For example, X = 0x002000 with dx = 0xFFF000 emits 0x001, 0x000, 0xFFF, 0xFFE.
- R5: A start with count N > 0 gives exactly N out_valid pulses, each one cycle long. The first pulse comes in the 6th cycle after the start edge, and later pulses follow every 6 cycles.
- R6: busy is high from the cycle after the start edge up to and including the last out_valid cycle. done is a one-cycle pulse in the cycle right after the last out_valid.
- R7: A start with count 0 emits no point, leaves busy low, and pulses done in the cycle after the start edge.
- R8: Load requests made while busy are ignored. The running and later outputs are those of the values loaded before start.
- R9: After a run, X, Y, dx and dy keep their final values. A new start, after only the count is reloaded, continues the curve from that state.
- R10: Load select codes: 0 = X, 1 = Y, 2 = dx, 3 = dy, 4 = ddx, 5 = ddy, 6 = count (taken from ld_data[15:0]). Code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for the word chosen by ld_sel |
| ld_sel | input | 3 | Load target select |
| ld_data | input | 24 | Load value (fixed point, or count in the low 16 bits) |
| start | input | 1 | Begin a run of count steps |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the run ends |
| out_valid | output | 1 | Point strobe |
| out_x | output | 12 | Integer part of X |
| out_y | output | 12 | Integer part of Y |

## Verification
The hardest condition to reach from the ports is a load request that arrives while a run is in progress. In that situation the ignored write would corrupt the remaining points and every later run. The bench raises start, waits until the first point has appeared, and then issues loads of dx and of the count. It then checks that the remaining points, and a further run that continues from the end state, still follow the values loaded before start. Continuation across runs and wrap-around through zero are reached by chaining runs without reloading the state words, and by starting near the origin with negative velocity.

// File: rtl/curve_stepper_pkg.sv
package curve_stepper_pkg;
    localparam int NREG    = 6;
    localparam int IDX_W   = 3;
    localparam logic [IDX_W-1:0] IDX_X   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_Y   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_DX  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_DY  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DDX = 3'd4;
    localparam logic [IDX_W-1:0] IDX_DDY = 3'd5;
    localparam logic [IDX_W-1:0] IDX_CNT = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD_DX,
        ST_ADD_DY,
        ST_ADD_X,
        ST_ADD_Y,
        ST_DEC,
        ST_EMIT
    } step_state_t;
endpackage

// File: rtl/cs_adder.sv
module cs_adder #(
    parameter int W = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    always_comb begin
        sum = a + b;
    end
endmodule

// File: rtl/cs_regfile.sv
module cs_regfile
    import curve_stepper_pkg::*;
#(
    parameter int W     = 24,
    parameter int INT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wa,
    input  logic [W-1:0]     wd,
    input  logic [IDX_W-1:0] ra,
    input  logic [IDX_W-1:0] rb,
    output logic [W-1:0]     rda,
    output logic [W-1:0]     rdb,
    output logic [INT_W-1:0] x_int,
    output logic [INT_W-1:0] y_int
);
    logic [W-1:0] mem_q [NREG];
    logic [W-1:0] mem_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (int'(wa) < NREG)) begin
            mem_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rda   = (int'(ra) < NREG) ? mem_q[ra] : '0;
        rdb   = (int'(rb) < NREG) ? mem_q[rb] : '0;
        x_int = mem_q[IDX_X][W-1 -: INT_W];
        y_int = mem_q[IDX_Y][W-1 -: INT_W];
    end

    // The acceleration words are never a write target of the adder path:
    // they change only through a write addressed to them.
    assert_accel_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (wa == IDX_DDX || wa == IDX_DDY)) |=>
            ($stable(mem_q[IDX_DDX]) && $stable(mem_q[IDX_DDY])));
endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
    import curve_stepper_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cnt_ld,
    input  logic [W-1:0]     ld_data,
    output logic             idle,
    output logic             alu_we,
    output logic [IDX_W-1:0] sel_a,
    output logic [IDX_W-1:0] sel_b,
    output logic             emit,
    output logic             done
);
    typedef struct packed {
        step_state_t      state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t cur_q, cur_d;

    always_comb begin
        cur_d      = cur_q;
        cur_d.done = 1'b0;
        alu_we     = 1'b0;
        sel_a      = IDX_X;
        sel_b      = IDX_DX;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (cnt_ld) cur_d.cnt = ld_data[CNT_W-1:0];
                if (start) begin
                    if (cur_q.cnt == '0) cur_d.done  = 1'b1;
                    else                 cur_d.state = ST_ADD_DX;
                end
            end
            ST_ADD_DX: begin
                alu_we = 1'b1; sel_a = IDX_DX; sel_b = IDX_DDX;
                cur_d.state = ST_ADD_DY;
            end
            ST_ADD_DY: begin
                alu_we = 1'b1; sel_a = IDX_DY; sel_b = IDX_DDY;
                cur_d.state = ST_ADD_X;
            end
            ST_ADD_X: begin
                alu_we = 1'b1; sel_a = IDX_X; sel_b = IDX_DX;
                cur_d.state = ST_ADD_Y;
            end
            ST_ADD_Y: begin
                alu_we = 1'b1; sel_a = IDX_Y; sel_b = IDX_DY;
                cur_d.state = ST_DEC;
            end
            ST_DEC: begin
                cur_d.cnt   = cur_q.cnt - 1'b1;
                cur_d.state = ST_EMIT;
            end
            ST_EMIT: begin
                if (cur_q.cnt == '0) begin
                    cur_d.state = ST_IDLE;
                    cur_d.done  = 1'b1;
                end else begin
                    cur_d.state = ST_ADD_DX;
                end
            end
            default: cur_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.cnt   <= '0;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    always_comb begin
        idle = (cur_q.state == ST_IDLE);
        emit = (cur_q.state == ST_EMIT);
        done = cur_q.done;
    end

    assert_emit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> !emit);

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && cur_q.cnt == '0) |=> (done && idle));

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(emit) || ($past(start) && $past(idle))));
endmodule

// File: rtl/curve_stepper.sv
module curve_stepper
    import curve_stepper_pkg::*;
#(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12,
    parameter int CNT_W  = 16,
    localparam int W     = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [W-1:0]     ld_data,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             out_valid,
    output logic [INT_W-1:0] out_x,
    output logic [INT_W-1:0] out_y
);
    logic             idle;
    logic             alu_we;
    logic [IDX_W-1:0] sel_a, sel_b;
    logic [W-1:0]     rda, rdb, sum;
    logic             host_we, cnt_ld;
    logic             rf_we;
    logic [IDX_W-1:0] rf_wa;
    logic [W-1:0]     rf_wd;

    always_comb begin
        host_we = ld_en && idle && (int'(ld_sel) < NREG);
        cnt_ld  = ld_en && idle && (ld_sel == IDX_CNT);
        rf_we   = host_we || alu_we;
        rf_wa   = alu_we ? sel_a : ld_sel;
        rf_wd   = alu_we ? sum   : ld_data;
        busy    = !idle;
    end

    cs_sequencer #(.CNT_W(CNT_W), .W(W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cnt_ld  (cnt_ld),
        .ld_data (ld_data),
        .idle    (idle),
        .alu_we  (alu_we),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .emit    (out_valid),
        .done    (done)
    );

    cs_regfile #(.W(W), .INT_W(INT_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd),
        .ra    (sel_a),
        .rb    (sel_b),
        .rda   (rda),
        .rdb   (rdb),
        .x_int (out_x),
        .y_int (out_y)
    );

    cs_adder #(.W(W)) u_add (
        .a   (rda),
        .b   (rdb),
        .sum (sum)
    );

    assert_busy_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_pos_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_valid && $past(out_valid)) |-> ($stable(out_x) && $stable(out_y)));
endmodule

// File: tb/curve_stepper_test.sv
`timescale 1ns/1ps
module curve_stepper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [23:0] ld_data = '0;
    logic        start = 1'b0;
    logic        busy, done, out_valid;
    logic [11:0] out_x, out_y;

    always #2 clk = ~clk;

    curve_stepper uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .start(start), .busy(busy), .done(done),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // model state
    logic [23:0] m_reg [6];
    logic [15:0] m_cnt;

    // monitor records
    int          npts;
    logic [11:0] px [64];
    logic [11:0] py [64];
    int          pc [64];
    logic        pb [64];
    int          ndone;
    int          done_cyc;
    int          t0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (npts < 64) begin
                    px[npts] = out_x; py[npts] = out_y;
                    pc[npts] = cyc;   pb[npts] = busy;
                end
                npts = npts + 1;
            end
            if (done) begin
                ndone    = ndone + 1;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] s, input logic [23:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        if (s < 3'd6) m_reg[s] = d;
        else if (s == 3'd6) m_cnt = d[15:0];
    endtask

    task automatic load_all(input logic [23:0] x, input logic [23:0] y,
                            input logic [23:0] dx, input logic [23:0] dy,
                            input logic [23:0] ddx, input logic [23:0] ddy,
                            input logic [15:0] n);
        load(3'd0, x);   load(3'd1, y);
        load(3'd2, dx);  load(3'd3, dy);
        load(3'd4, ddx); load(3'd5, ddy);
        load(3'd6, {8'h0, n});
    endtask

    task automatic kick();
        @(negedge clk);
        npts = 0; ndone = 0; done_cyc = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
    endtask

    task automatic wait_done(input string tag);
        int w = 0;
        while (ndone == 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (ndone == 0) begin
            errors++; checks++;
            $display("FAIL %s watchdog actual=no_done expected=done", tag);
        end
        @(negedge clk);
    endtask

    // compare recorded run against the model; advances the model state
    task automatic verify(input string tag, input int n);
        logic [11:0] ex, ey;
        chk({tag, " point count"}, npts, n);
        for (int k = 0; k < n; k++) begin
            m_reg[2] = m_reg[2] + m_reg[4];
            m_reg[3] = m_reg[3] + m_reg[5];
            m_reg[0] = m_reg[0] + m_reg[2];
            m_reg[1] = m_reg[1] + m_reg[3];
            ex = m_reg[0][23:12];
            ey = m_reg[1][23:12];
            if (k < npts && k < 64) begin
                chk({tag, " x"}, px[k], ex);
                chk({tag, " y"}, py[k], ey);
                chk({tag, " R5 timing"}, pc[k] - t0, 5 + 6 * k);
                chk({tag, " R6 busy at point"}, pb[k], 1);
            end
        end
        m_cnt = '0;
        chk({tag, " R6 done timing"}, done_cyc - t0, (n == 0) ? 0 : 6 * n);
        chk({tag, " R6 single done"}, ndone, 1);
        chk({tag, " R6 idle after"}, busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 valid", out_valid, 0);
        chk("R1 out_x", out_x, 0);
        chk("R1 out_y", out_y, 0);
    endtask

    task automatic t_line();
        load_all(24'h064000, 24'h0C8000, 24'h001000, 24'h000800, 24'h0, 24'h0, 16'd6);
        kick();
        chk("R6 busy after start", busy, 1);
        wait_done("R2 line");
        verify("R2 line", 6);
    endtask

    task automatic t_curve();
        load_all(24'h100000, 24'h200000, 24'h000400, 24'hFFE000, 24'h000300, 24'h000180, 16'd9);
        kick();
        wait_done("R3 curve");
        verify("R3 curve", 9);
    endtask

    task automatic t_wrap();
        load_all(24'h002000, 24'h001800, 24'hFFF000, 24'hFFF800, 24'h0, 24'h0, 16'd4);
        kick();
        wait_done("R4 wrap");
        chk("R4 last x", px[3], 12'hFFE);
        verify("R4 wrap", 4);
    endtask

    task automatic t_zero();
        load(3'd6, 24'h0);
        kick();
        chk("R7 busy stays low", busy, 0);
        repeat (10) @(negedge clk);
        chk("R7 no points", npts, 0);
        chk("R7 done timing", done_cyc - t0, 0);
        chk("R7 single done", ndone, 1);
    endtask

    task automatic t_busy_load();
        logic [23:0] save_dx;
        load_all(24'h300000, 24'h300000, 24'h002000, 24'h001000, 24'h000100, 24'h0, 16'd5);
        kick();
        while (npts == 0) @(negedge clk);
        save_dx = m_reg[2];
        load(3'd2, 24'h7FF000);
        load(3'd6, 24'd40);
        load(3'd0, 24'h000000);
        m_reg[2] = save_dx; m_cnt = 16'd5; m_reg[0] = 24'h300000;
        wait_done("R8 busy load");
        verify("R8 busy load", 5);
    endtask

    task automatic t_continue();
        load(3'd6, 24'd3);
        kick();
        wait_done("R9 continue");
        verify("R9 continue", 3);
    endtask

    task automatic t_bad_sel();
        ld_en = 1'b0;
        load(3'd7, 24'hABCDEF);
        load(3'd6, 24'd2);
        kick();
        wait_done("R10 sel7");
        verify("R10 sel7", 2);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        m_cnt = '0; npts = 0; ndone = 0; done_cyc = -1; t0 = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_line();
        t_curve();
        t_wrap();
        t_zero();
        t_busy_load();
        t_continue();
        t_bad_sel();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL global watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule